// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic core of a small 8-bit processor datapath. It holds an accumulator and a five-flag status word. On each execute strobe it combines the accumulator with an 8-bit operand, using the operation picked by a 3-bit select. The operand may come from a register, from memory or from an immediate byte. Unless the operation is a compare, the result goes back into the accumulator. The status flags are rebuilt from the same result.

A separate load strobe writes the operand straight into the accumulator and leaves the flags alone. Surrounding logic uses it to preset the accumulator. All results are registered, so they appear on the outputs one rising edge after the strobe.

Top module: `acc_alu_unit`

## Requirements
- R1: After reset the accumulator reads 0x00 and the flag word reads 0x02.
- R2: When `loadStb` is high, the next rising edge copies `operand` into the accumulator and leaves the flag word unchanged. `loadStb` takes priority over `execStb`.
- R3: With `execStb` high, select 0 writes acc+operand and select 1 writes acc+operand+CY. CY becomes the carry out of bit 7.
- R4: Select 2 writes acc−operand and select 3 writes acc−operand−CY. CY becomes 1 exactly when the true difference is negative (a borrow).
- R5: Select 4 writes AND, select 5 writes XOR and select 6 writes OR of acc and operand. Each of them clears both CY and AC.
- R6: Select 7 (compare) sets the flags exactly as select 2 would, and the accumulator keeps its value.
- R7: The flag word places sign (result bit 7) at bit 7, zero at bit 6, AC at bit 4, parity at bit 2 and CY at bit 0. Bit 1 reads 1 and bits 5 and 3 read 0.
- R8: Parity is 1 when the result has an even number of one bits.
- R9: On an add, AC is the carry out of bit 3, with the carry-in included. On a subtract or compare, AC is the carry out of bit 3 of acc[3:0] + ~operand[3:0] + (1 − borrow-in).
- R10: With neither strobe high, the accumulator and the flag word hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| opSel | input | 3 | Operation select (see R3 to R6) |
| operand | input | 8 | Second operand, or the load value |
| execStb | input | 1 | Perform the selected operation |
| loadStb | input | 1 | Load operand into accumulator |
| accOut | output | 8 | Accumulator |
| flagWord | output | 8 | Status flag word (layout in R7) |

## Verification
Both accumulator and flag results are due exactly one rising edge after the strobe. No output is combinational from the inputs. The bench drives each strobe at a falling edge and compares both outputs at the following falling edge, half a period after the result is registered. A reference model in the bench then carries that state forward for the next step, so a chain of dependent operations (especially carry and borrow chaining) is checked cycle by cycle.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DATA_W   = 8;
  localparam int NIB_W    = DATA_W / 2;
  localparam int SEL_W    = 3;
  localparam int BIT_SIGN = 7;
  localparam int BIT_ZERO = 6;
  localparam int BIT_HALF = 4;
  localparam int BIT_PAR  = 2;
  localparam int BIT_ONE  = 1;
  localparam int BIT_CY   = 0;

  typedef enum logic [SEL_W-1:0] {
    OP_ADD = 3'd0, OP_ADC = 3'd1, OP_SUB = 3'd2, OP_SBB = 3'd3,
    OP_AND = 3'd4, OP_XOR = 3'd5, OP_OR  = 3'd6, OP_CMP = 3'd7
  } aluOpE;

  typedef enum logic [1:0] { LG_AND = 2'd0, LG_XOR = 2'd1, LG_OR = 2'd2 } logicSelE;

  typedef struct packed {
    logic     loadAcc;
    logic     writeAcc;
    logic     writeFlags;
    logic     arith;
    logic     subtract;
    logic     useCarry;
    logicSelE logicSel;
  } ctrlT;
endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] opSel,
  input  logic             execStb,
  input  logic             loadStb,
  output ctrlT             ctl
);
  always_comb begin
    ctl = '0;
    if (loadStb) begin
      ctl.loadAcc = 1'b1;
    end else if (execStb) begin
      ctl.writeFlags = 1'b1;
      ctl.writeAcc   = (aluOpE'(opSel) != OP_CMP);
      unique case (aluOpE'(opSel))
        OP_ADD: ctl.arith = 1'b1;
        OP_ADC: begin ctl.arith = 1'b1; ctl.useCarry = 1'b1; end
        OP_SUB: begin ctl.arith = 1'b1; ctl.subtract = 1'b1; end
        OP_SBB: begin ctl.arith = 1'b1; ctl.subtract = 1'b1; ctl.useCarry = 1'b1; end
        OP_AND: ctl.logicSel = LG_AND;
        OP_XOR: ctl.logicSel = LG_XOR;
        OP_OR:  ctl.logicSel = LG_OR;
        OP_CMP: begin ctl.arith = 1'b1; ctl.subtract = 1'b1; end
        default: ctl.logicSel = LG_AND;
      endcase
    end
  end

  AST_LOAD_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |-> !ctl.writeFlags && !ctl.writeAcc); // R2
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (execStb && !loadStb && opSel == OP_CMP) |-> ctl.writeFlags && !ctl.writeAcc); // R6
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlT              ctl,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] flagWord
);
  logic [DATA_W-1:0] acc;
  logic signF, zeroF, halfF, parF, cyF;

  logic [DATA_W-1:0] opnd;
  logic              carryIn;
  logic [NIB_W:0]    lowSum;
  logic [DATA_W:0]   fullSum;
  logic [DATA_W-1:0] logicRes;
  logic [DATA_W-1:0] result;
  logic              newCy;
  logic              newHalf;

  // Subtraction runs as addition of the inverted operand; the carry sense inverts.
  assign opnd    = ctl.subtract ? ~operand : operand;
  assign carryIn = ctl.subtract ? ~(ctl.useCarry & cyF) : (ctl.useCarry & cyF);
  assign lowSum  = {1'b0, acc[NIB_W-1:0]} + {1'b0, opnd[NIB_W-1:0]} + {{NIB_W{1'b0}}, carryIn};
  assign fullSum = {1'b0, acc} + {1'b0, opnd} + {{DATA_W{1'b0}}, carryIn};

  always_comb begin
    unique case (ctl.logicSel)
      LG_XOR:  logicRes = acc ^ operand;
      LG_OR:   logicRes = acc | operand;
      default: logicRes = acc & operand;
    endcase
  end

  assign result  = ctl.arith ? fullSum[DATA_W-1:0] : logicRes;
  assign newCy   = ctl.arith & (ctl.subtract ? ~fullSum[DATA_W] : fullSum[DATA_W]);
  assign newHalf = ctl.arith & lowSum[NIB_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc   <= '0;
      signF <= 1'b0;
      zeroF <= 1'b0;
      halfF <= 1'b0;
      parF  <= 1'b0;
      cyF   <= 1'b0;
    end else begin
      if (ctl.loadAcc)       acc <= operand;
      else if (ctl.writeAcc) acc <= result;
      if (ctl.writeFlags) begin
        signF <= result[DATA_W-1];
        zeroF <= (result == '0);
        halfF <= newHalf;
        parF  <= ~^result;
        cyF   <= newCy;
      end
    end
  end

  always_comb begin
    flagWord           = '0;
    flagWord[BIT_SIGN] = signF;
    flagWord[BIT_ZERO] = zeroF;
    flagWord[BIT_HALF] = halfF;
    flagWord[BIT_PAR]  = parF;
    flagWord[BIT_ONE]  = 1'b1;
    flagWord[BIT_CY]   = cyF;
  end
  assign accOut = acc;

  AST_ZERO_TRACKS_ACC: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.writeAcc && ctl.writeFlags) |=> flagWord[BIT_ZERO] == (accOut == '0)); // R7
  AST_PARITY_TRACKS_ACC: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.writeAcc && ctl.writeFlags) |=> flagWord[BIT_PAR] == ~^accOut); // R8
  AST_SIGN_TRACKS_ACC: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.writeAcc && ctl.writeFlags) |=> flagWord[BIT_SIGN] == accOut[DATA_W-1]); // R7
  AST_LOGIC_CLEARS_CY: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.writeFlags && !ctl.arith) |=> !flagWord[BIT_CY] && !flagWord[BIT_HALF]); // R5
  AST_CMP_HOLDS_ACC: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.writeFlags && !ctl.writeAcc) |=> $stable(accOut)); // R6
  AST_LOAD_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadAcc |=> $stable(flagWord)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.loadAcc && !ctl.writeFlags) |=> $stable(accOut) && $stable(flagWord)); // R10
endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
  import alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEL_W-1:0]  opSel,
  input  logic [DATA_W-1:0] operand,
  input  logic              execStb,
  input  logic              loadStb,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] flagWord
);
  ctrlT ctl;

  alu_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .opSel(opSel),
    .execStb(execStb), .loadStb(loadStb), .ctl(ctl)
  );

  alu_datapath uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .operand(operand),
    .accOut(accOut), .flagWord(flagWord)
  );
endmodule

// File: tb/sim_acc_alu_unit.sv
module sim_acc_alu_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] opSel = '0;
  logic [7:0] operand = '0;
  logic       execStb = 1'b0;
  logic       loadStb = 1'b0;
  logic [7:0] accOut;
  logic [7:0] flagWord;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] mAcc;
  logic [7:0] mFlags;

  always #10 clk = ~clk;  // 50 MHz

  acc_alu_unit u0 (
    .clk(clk), .rstN(rstN), .opSel(opSel), .operand(operand),
    .execStb(execStb), .loadStb(loadStb), .accOut(accOut), .flagWord(flagWord)
  );

  function automatic logic [7:0] packFlags(input logic s, z, h, p, c);
    return {s, z, 1'b0, h, 1'b0, p, 1'b1, c};
  endfunction

  // Reference model: returns {newAcc, newFlags}
  function automatic logic [15:0] model(input logic [2:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic [7:0] fl);
    int r, ci, h, c;
    logic [7:0] res;
    ci = 0; h = 0; c = 0;
    case (op)
      3'd0, 3'd1: begin
        ci = (op == 3'd1) ? int'(fl[0]) : 0;
        r = int'(a) + int'(b) + ci;
        c = (r > 255);
        h = ((int'(a) & 15) + (int'(b) & 15) + ci) > 15;
        res = r[7:0];
      end
      3'd2, 3'd3, 3'd7: begin
        ci = (op == 3'd3) ? int'(fl[0]) : 0;
        r = int'(a) - int'(b) - ci;
        c = (r < 0);
        h = ((int'(a) & 15) + ((~int'(b)) & 15) + (1 - ci)) > 15;
        res = r[7:0];
      end
      3'd4: res = a & b;
      3'd5: res = a ^ b;
      default: res = a | b;
    endcase
    return {(op == 3'd7) ? a : res,
            packFlags(res[7], res == 8'd0, h[0], ~^res, c[0])};
  endfunction

  function automatic string reqOf(input logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R3";
      3'd2, 3'd3: return "R4";
      3'd7:       return "R6";
      default:    return "R5";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] gotA, expA, gotF, expF);
    checks++;
    if (gotA !== expA || gotF !== expF) begin
      fails++;
      $display("FAIL %s: acc=%02h flags=%02h expected acc=%02h flags=%02h",
               req, gotA, gotF, expA, expF);
    end
  endtask

  // drive at negedge, result checked at following negedge
  task automatic step(input logic [2:0] op, input logic [7:0] val,
                      input logic ex, input logic ld, input string req);
    logic [15:0] m;
    opSel = op; operand = val; execStb = ex; loadStb = ld;
    if (ld) mAcc = val;
    else if (ex) begin
      m = model(op, mAcc, val, mFlags);
      mAcc = m[15:8]; mFlags = m[7:0];
    end
    @(negedge clk);
    execStb = 1'b0; loadStb = 1'b0;
    check(req, accOut, mAcc, flagWord, mFlags);
  endtask

  initial begin
    int seedDummy;
    logic [2:0] rop;
    seedDummy = $urandom(32'd1977);
    mAcc = 8'h00; mFlags = 8'h02;
    repeat (2) @(negedge clk);
    check("R1", accOut, 8'h00, flagWord, 8'h02);  // R1 reset state
    rstN = 1'b1;
    @(negedge clk);
    check("R1", accOut, 8'h00, flagWord, 8'h02);

    // R2 load, flags untouched
    step(3'd0, 8'hFF, 1'b0, 1'b1, "R2");
    // R3 wrap to zero: Z, AC, P, CY set -> 0x57 (literal)
    step(3'd0, 8'h01, 1'b1, 1'b0, "R3");
    check("R7", accOut, 8'h00, flagWord, 8'h57);
    // R3 add with carry uses CY=1: 0 + 0x0F + 1 = 0x10, AC set
    step(3'd1, 8'h0F, 1'b1, 1'b0, "R3");
    check("R9", accOut, 8'h10, flagWord, 8'h02 | 8'h10);
    // R2 load takes priority over exec
    step(3'd0, 8'h00, 1'b1, 1'b1, "R2");
    // R4 borrow: 0 - 1 = 0xFF -> S,P,CY set, AC clear = 0x87 (literal)
    step(3'd2, 8'h01, 1'b1, 1'b0, "R4");
    check("R8", accOut, 8'hFF, flagWord, 8'h87);
    // R4 subtract with borrow consumes CY
    step(3'd3, 8'h0F, 1'b1, 1'b0, "R4");
    // R6 compare equal: acc kept, Z set
    step(3'd7, accOut, 1'b1, 1'b0, "R6");
    // R5 logic ops clear CY after a borrow
    step(3'd2, 8'hFF, 1'b1, 1'b0, "R4");
    step(3'd4, 8'h3C, 1'b1, 1'b0, "R5");
    step(3'd6, 8'hC3, 1'b1, 1'b0, "R5");
    step(3'd5, 8'hFF, 1'b1, 1'b0, "R5");
    // R10 idle: no strobe, opSel/operand wiggle
    step(3'd1, 8'hAA, 1'b0, 1'b0, "R10");
    step(3'd7, 8'h55, 1'b0, 1'b0, "R10");

    for (int i = 0; i < 400; i++) begin
      rop = 3'($urandom_range(0, 7));
      case ($urandom_range(0, 9))
        0:       step(rop, 8'($urandom), 1'b0, 1'b1, "R2");
        1:       step(rop, 8'($urandom), 1'b0, 1'b0, "R10");
        default: step(rop, 8'($urandom), 1'b1, 1'b0, reqOf(rop));
      endcase
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule